// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the combinational integer datapath unit of a small load/store processor. It takes two operand words and a 3-bit operation select. It returns a result word and two flags. The zero flag is high when the result word is all zeros. The overflow flag reports signed two's complement overflow of addition and subtraction.

The unit supports bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than. One adder serves the three arithmetic operations. The most significant select bit both inverts the second operand and supplies the carry into bit 0, so subtraction is computed as A + ~B + 1. Set-on-less-than takes its answer from that same difference. It corrects the sign with the overflow bit, so the comparison stays right when the difference overflows. The unit has no exception path: overflow is only reported on its flag. Equality is tested by subtracting and reading the zero flag.

Top module: `word_alu`

## Requirements
- R1: With op_sel = 3'b000 the result is the bitwise AND of opnd_a and opnd_b.
- R2: With op_sel = 3'b001 the result is the bitwise OR of opnd_a and opnd_b.
- R3: With op_sel = 3'b010 the result is opnd_a + opnd_b modulo 2^WIDTH.
- R4: With op_sel = 3'b110 the result is opnd_a - opnd_b modulo 2^WIDTH.
- R5: With op_sel = 3'b111, result bit 0 is 1 exactly when opnd_a is less than opnd_b as signed two's complement numbers, including when opnd_a - opnd_b overflows. All other result bits are 0.
- R6: is_zero is 1 exactly when every result bit is 0. Subtracting equal operands therefore sets it.
- R7: For addition (3'b010), ovf is 1 exactly when both operands have the same sign bit and the sign bit of the sum differs from it.
- R8: For subtraction (3'b110), ovf is 1 exactly when the operands' sign bits differ and the sign bit of the difference differs from that of opnd_a.
- R9: The codes 3'b011, 3'b100 and 3'b101 give an all-zero result. ovf is 0 for every code other than 3'b010 and 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation select |
| result | output | WIDTH | Operation result |
| is_zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so every fault shows at the ports in the same cycle as the operand pattern that exercises it. A faulty inversion or carry-in shows as a difference that is off by one or that equals the sum. A wrong overflow term shows only at sign boundaries, and there set-on-less-than flips as well. For this reason every code is swept over all operand pairs of a 4-bit instance. A 32-bit instance adds directed cases at the extremes of the signed range.

// File: rtl/word_alu.sv
module word_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             b_neg;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             ovf_raw;
  logic             lt_bit;
  logic             arith;

  assign b_neg   = op_sel[2];
  assign b_eff   = b_neg ? ~opnd_b : opnd_b;
  assign sum     = opnd_a + b_eff + {{(WIDTH-1){1'b0}}, b_neg};
  assign ovf_raw = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
  assign lt_bit  = sum[MSB] ^ ovf_raw;
  assign arith   = (op_sel == 3'b010) || (op_sel == 3'b110);

  always_comb begin
    case (op_sel)
      3'b000:  result = opnd_a & opnd_b;
      3'b001:  result = opnd_a | opnd_b;
      3'b010,
      3'b110:  result = sum;
      3'b111:  result = {{(WIDTH-1){1'b0}}, lt_bit};
      default: result = '0;
    endcase
  end

  assign is_zero = ~|result;
  assign ovf     = arith & ovf_raw;
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             is_zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide_sum;
  logic [WIDTH:0] wide_dif;
  assign wide_sum = {opnd_a[MSB], opnd_a} + {opnd_b[MSB], opnd_b};
  assign wide_dif = {opnd_a[MSB], opnd_a} - {opnd_b[MSB], opnd_b};

  always_comb begin
    if (op_sel == 3'b000)
      a_r1_and: assert (result == (opnd_a & opnd_b)) else $error("R1 and");
    if (op_sel == 3'b001)
      a_r2_or: assert (result == (opnd_a | opnd_b)) else $error("R2 or");
    if (op_sel == 3'b010)
      a_r3_add: assert (result == wide_sum[WIDTH-1:0]) else $error("R3 add");
    if (op_sel == 3'b110)
      a_r4_sub: assert (result == wide_dif[WIDTH-1:0]) else $error("R4 sub");
    if (op_sel == 3'b111)
      a_r5_slt: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
        else $error("R5 slt");
    if (op_sel == 3'b110 && opnd_a == opnd_b)
      a_r6_eq_zero: assert (is_zero) else $error("R6 zero");
    if (op_sel == 3'b010)
      a_r7_add_ovf: assert (ovf == (wide_sum[WIDTH] != wide_sum[MSB])) else $error("R7 ovf");
    if (op_sel == 3'b110)
      a_r8_sub_ovf: assert (ovf == (wide_dif[WIDTH] != wide_dif[MSB])) else $error("R8 ovf");
    if (op_sel != 3'b010 && op_sel != 3'b110)
      a_r9_no_overflow: assert (!ovf) else $error("R9 ovf");
    if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
      a_r9_unused_zero: assert (result == '0) else $error("R9 result");
  end
endmodule

bind word_alu word_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
  .result(result), .is_zero(is_zero), .ovf(ovf)
);

// File: tb/word_alu_test.sv
module word_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] a32 = '0, b32 = '0;
  logic [2:0]  op32 = '0;
  logic [31:0] r32;
  logic        z32, v32;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [2:0]  op4 = '0;
  logic [3:0]  r4;
  logic        z4, v4;

  word_alu #(.WIDTH(32)) uut (.opnd_a(a32), .opnd_b(b32), .op_sel(op32),
                              .result(r32), .is_zero(z32), .ovf(v32));
  word_alu #(.WIDTH(4)) uut_small (.opnd_a(a4), .opnd_b(b4), .op_sel(op4),
                                   .result(r4), .is_zero(z4), .ovf(v4));

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [2:0] op);
    if (op == 3'b010) return "R7";
    if (op == 3'b110) return "R8";
    return "R9";
  endfunction

  task automatic model(input int w, input longint a, input longint b, input logic [2:0] op,
                       output longint r, output longint z, output longint v);
    longint full = longint'(1) << w;
    longint half = longint'(1) << (w - 1);
    longint sa = (a >= half) ? a - full : a;
    longint sb = (b >= half) ? b - full : b;
    longint s;
    v = 0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin s = sa + sb; r = (a + b) & (full - 1); v = (s >= half || s < -half) ? 1 : 0; end
      3'b110: begin s = sa - sb; r = (a - b) & (full - 1); v = (s >= half || s < -half) ? 1 : 0; end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
    z = (r == 0) ? 1 : 0;
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    longint r, z, v;
    @(posedge clk);
    a32 = a; b32 = b; op32 = op;
    @(negedge clk);
    model(32, longint'(a), longint'(b), op, r, z, v);
    chk(res_tag(op), "result32", longint'(r32), r);
    chk("R6", "zero32", longint'(z32), z);
    chk(ovf_tag(op), "ovf32", longint'(v32), v);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "idle zero flag", longint'(z32), 1);
    chk("R1", "idle result", longint'(r32), 0);

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          longint r, z, v;
          @(posedge clk);
          a4 = 4'(a); b4 = 4'(b); op4 = 3'(op);
          @(negedge clk);
          model(4, longint'(a), longint'(b), 3'(op), r, z, v);
          chk(res_tag(3'(op)), "result4", longint'(r4), r);
          chk("R6", "zero4", longint'(z4), z);
          chk(ovf_tag(3'(op)), "ovf4", longint'(v4), v);
        end

    run32(32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000); // R1
    run32(32'hF0F0_0000, 32'h0000_1234, 3'b001); // R2
    run32(32'h7FFF_FFFF, 32'h0000_0001, 3'b010); // R3 R7 positive overflow
    run32(32'h8000_0000, 32'h8000_0000, 3'b010); // R7 negative overflow, R6 zero
    run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b010); // R3 wrap, no overflow
    run32(32'h8000_0000, 32'h0000_0001, 3'b110); // R4 R8 overflow
    run32(32'h1234_5678, 32'h1234_5678, 3'b110); // R6 equality
    run32(32'h0000_0000, 32'h8000_0000, 3'b110); // R8 overflow from zero
    run32(32'h8000_0000, 32'h0000_0001, 3'b111); // R5 with overflowed difference
    run32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111); // R5 with overflowed difference
    run32(32'hFFFF_FFFE, 32'hFFFF_FFFF, 3'b111); // R5
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011); // R9
    run32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b100); // R9
    run32(32'h8000_0000, 32'h0000_0001, 3'b101); // R9

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule